// File: doc/BRIEF.md
# Pulse Accumulator with Gated Time Mode

This block is a 16-bit accumulator fed by a single external input pin. It has two ways of counting. In event mode it counts edges on the pin, and a control bit chooses whether rising or falling edges count. In gated mode it counts ticks of the bus clock divided by 64, but only while the pin sits at its active level. The edge that closes such a window raises an input flag. That flag lets software measure how long the pin stayed high or low.

Software reaches the block over a simple byte bus with four addresses:

| Address | Register |
|---|---|
| 0 | Control |
| 1 | Flags |
| 2 | Count high byte |
| 3 | Count low byte |

Two flags are kept: an input flag and a wrap (overflow) flag. Each flag drives an interrupt output through its own enable bit. Flags are cleared by writing 1 to them. The 16-bit count stays coherent under byte access because two holding registers bridge the two halves.

Top module: `pulse_acc`

## Requirements
- R1: After reset every register reads 0x00. Control bit 7 always reads 0, even after a write of 0x80.
- R2: While control bit 6 (enable) is 0, pin activity changes neither the count nor the input flag, whatever the mode (bit 5) and edge-select (bit 4) settings are.
- R3: With enable=1 and mode=0 (event mode), the count increments once per counted edge of the pin and never by more than 1 per cycle. Edge-select 1 counts rising edges and 0 counts falling edges, and each counted edge sets the input flag (flag register bit 0).
- R4: With enable=1, mode=1 and edge-select=0, the count increments once per 64 clock cycles while the pin is high. The first increment comes 64 cycles after enable is written, because the prescaler is held at zero while disabled. The falling edge of the pin sets the input flag. No counting occurs while the pin is low.
- R5: With enable=1, mode=1 and edge-select=1, the count increments once per 64 cycles while the pin is low. The rising edge sets the input flag.
- R6: An increment from 0xFFFF wraps the count to 0x0000 and sets the wrap flag (flag register bit 1).
- R7: Writing the flag register clears each flag whose data bit is 1. Flags whose data bit is 0 are unchanged.
- R8: If a flag's set event and a clear write hit in the same cycle, the flag ends up set.
- R9: The wrap interrupt output equals wrap flag AND control bit 1. The input interrupt output equals input flag AND control bit 0.
- R10: A write to address 2 is buffered. The following write to address 3 loads the count with {buffered high byte, written low byte}. A read of address 2 returns the live high byte and latches the low byte; later reads of address 3 return that latched byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pin_i | input | 1 | Asynchronous accumulator input |
| addr_i | input | 2 | Register address |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| ovf_irq_o | output | 1 | Wrap interrupt |
| inp_irq_o | output | 1 | Input interrupt |

## Verification
Event mode is tried with bursts of full pulses, with and without a trailing unmatched rising edge. The trailing edge is what separates a rising-edge count from a falling-edge count, and a zero-pulse vector shows the flag stays clear when nothing is counted. The disabled vectors reuse the same bursts to show that enable gates everything. Gated mode is run with the pin held at each polarity for a known number of 64-cycle periods and then released. The count must match exactly, which separates a reset-held prescaler from a free-running one and shows counting stops outside the window. A wrap timed to land on the same edge as a flag-clear write shows which of the two wins.

// File: rtl/pa_pkg.sv
package pa_pkg;
  localparam int DATA_W = 8;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_FLAG = 2'd1;
  localparam logic [1:0] A_CNTH = 2'd2;
  localparam logic [1:0] A_CNTL = 2'd3;

  typedef struct packed {
    logic       rsv;
    logic       en;
    logic       mode;     // 1: gated time
    logic       edge_sel; // 1: rising / low-active gate
    logic [1:0] clk_sel;
    logic       ovie;
    logic       inie;
  } ctrl_t;
endpackage

// File: rtl/pa_sync_edge.sv
module pa_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[i] <= 1'b0;
        else if (i == 0) sync_q[i] <= pin_i;
        else sync_q[i] <= sync_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[STAGES-1];
  end

  assign lvl_o  = sync_q[STAGES-1];
  assign rise_o =  lvl_o & ~prev_q;
  assign fall_o = ~lvl_o &  prev_q;
endmodule

// File: rtl/pa_prescale.sv
module pa_prescale #(
  parameter int DIV = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int PW = $clog2(DIV);
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         div_q <= '0;
    else if (!run_i)     div_q <= '0;
    else if (div_q == LAST) div_q <= '0;
    else                 div_q <= div_q + 1'b1;
  end

  assign tick_o = run_i && (div_q == LAST);
endmodule

// File: rtl/pa_counter.sv
module pa_counter #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inc_i,
  input  logic              wr_hi_i,
  input  logic              wr_lo_i,
  input  logic              rd_hi_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [2*DATA_W-1:0] cnt_o,
  output logic [DATA_W-1:0] lo_hold_o,
  output logic              wrap_o
);
  localparam int CW = 2 * DATA_W;

  logic [CW-1:0]     cnt_q;
  logic [DATA_W-1:0] hi_buf_q;
  logic [DATA_W-1:0] lo_hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (wr_lo_i) cnt_q <= {hi_buf_q, wdata_i};
    else if (inc_i)   cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_buf_q  <= '0;
      lo_hold_q <= '0;
    end else begin
      if (wr_hi_i) hi_buf_q  <= wdata_i;
      if (rd_hi_i) lo_hold_q <= cnt_q[DATA_W-1:0];
    end
  end

  assign cnt_o     = cnt_q;
  assign lo_hold_o = lo_hold_q;
  assign wrap_o    = inc_i && !wr_lo_i && (&cnt_q);
endmodule

// File: rtl/pa_regs.sv
module pa_regs
  import pa_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_ctrl_i,
  input  logic              wr_flag_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ovf_set_i,
  input  logic              inp_set_i,
  output ctrl_t             ctrl_o,
  output logic              ovf_o,
  output logic              inp_o
);
  ctrl_t ctrl_q;
  logic  ovf_q, inp_q;
  logic  ovf_clr, inp_clr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else if (wr_ctrl_i) begin
      ctrl_q     <= ctrl_t'(wdata_i);
      ctrl_q.rsv <= 1'b0;
    end
  end

  assign ovf_clr = wr_flag_i && wdata_i[1];
  assign inp_clr = wr_flag_i && wdata_i[0];

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_q <= 1'b0;
      inp_q <= 1'b0;
    end else begin
      ovf_q <= ovf_set_i | (ovf_q & ~ovf_clr);
      inp_q <= inp_set_i | (inp_q & ~inp_clr);
    end
  end

  assign ctrl_o = ctrl_q;
  assign ovf_o  = ovf_q;
  assign inp_o  = inp_q;
endmodule

// File: rtl/pulse_acc.sv
module pulse_acc
  import pa_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PRE_DIV     = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pin_i,
  input  logic [1:0]        addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ovf_irq_o,
  output logic              inp_irq_o
);
  localparam int CW = 2 * DATA_W;

  ctrl_t          ctrl;
  logic           lvl, rise, fall, tick;
  logic           sel_edge, gate_on, inc, inp_set, wrap;
  logic           ovf_flag, inp_flag;
  logic [CW-1:0]  cnt;
  logic [DATA_W-1:0] lo_hold;
  logic           wr_ctrl, wr_flag, wr_hi, wr_lo, rd_hi;

  assign wr_ctrl = wr_i && (addr_i == A_CTRL);
  assign wr_flag = wr_i && (addr_i == A_FLAG);
  assign wr_hi   = wr_i && (addr_i == A_CNTH);
  assign wr_lo   = wr_i && (addr_i == A_CNTL);
  assign rd_hi   = rd_i && (addr_i == A_CNTH);

  pa_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .pin_i,
    .lvl_o(lvl), .rise_o(rise), .fall_o(fall)
  );

  pa_prescale #(.DIV(PRE_DIV)) u_pre (
    .clk_i, .rst_ni, .run_i(ctrl.en), .tick_o(tick)
  );

  // edge_sel picks the counting edge in event mode and the closing edge in gated mode
  assign sel_edge = ctrl.edge_sel ? rise : fall;
  assign gate_on  = ctrl.edge_sel ? ~lvl : lvl;
  assign inc      = ctrl.en && (ctrl.mode ? (tick && gate_on) : sel_edge);
  assign inp_set  = ctrl.en && sel_edge;

  pa_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk_i, .rst_ni,
    .inc_i(inc), .wr_hi_i(wr_hi), .wr_lo_i(wr_lo), .rd_hi_i(rd_hi),
    .wdata_i, .cnt_o(cnt), .lo_hold_o(lo_hold), .wrap_o(wrap)
  );

  pa_regs u_regs (
    .clk_i, .rst_ni,
    .wr_ctrl_i(wr_ctrl), .wr_flag_i(wr_flag), .wdata_i,
    .ovf_set_i(wrap), .inp_set_i(inp_set),
    .ctrl_o(ctrl), .ovf_o(ovf_flag), .inp_o(inp_flag)
  );

  always_comb begin
    unique case (addr_i)
      A_CTRL:  rdata_o = {1'b0, ctrl[DATA_W-2:0]};
      A_FLAG:  rdata_o = {{(DATA_W-2){1'b0}}, ovf_flag, inp_flag};
      A_CNTH:  rdata_o = cnt[CW-1:DATA_W];
      default: rdata_o = lo_hold;
    endcase
  end

  assign ovf_irq_o = ovf_flag & ctrl.ovie;
  assign inp_irq_o = inp_flag & ctrl.inie;
endmodule

// File: rtl/pa_checker.sv
module pa_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        en,
  input logic        cnt_wr,
  input logic [15:0] cnt,
  input logic        inc,
  input logic        wrap,
  input logic        ovf_flag,
  input logic        inp_flag,
  input logic        inp_set,
  input logic        ovf_irq,
  input logic        inp_irq
);
  AST_HOLD_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en && !cnt_wr) |=> $stable(cnt)); // R2

  AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_wr |=> (cnt == $past(cnt) || cnt == $past(cnt) + 16'd1)); // R3

  AST_WRAP_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc && !cnt_wr && cnt == 16'hFFFF) |=> (ovf_flag && cnt == 16'h0000)); // R6

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap || inp_set) |=> ((ovf_flag || !$past(wrap)) && (inp_flag || !$past(inp_set)))); // R8

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((!ovf_irq || ovf_flag) && (!inp_irq || inp_flag))); // R9
endmodule

bind pulse_acc pa_checker u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .en       (ctrl.en),
  .cnt_wr   (wr_lo),
  .cnt      (cnt),
  .inc      (inc),
  .wrap     (wrap),
  .ovf_flag (ovf_flag),
  .inp_flag (inp_flag),
  .inp_set  (inp_set),
  .ovf_irq  (ovf_irq_o),
  .inp_irq  (inp_irq_o)
);

// File: tb/sim_pulse_acc.sv
`timescale 1ns/1ps
module sim_pulse_acc;
  logic       clk = 0, rst_ni = 0, pin = 0;
  logic [1:0] addr = 0;
  logic       wr = 0, rd = 0;
  logic [7:0] wdata = 0, rdata;
  logic       ovf_irq, inp_irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pulse_acc u0 (
    .clk_i(clk), .rst_ni(rst_ni), .pin_i(pin), .addr_i(addr),
    .wr_i(wr), .rd_i(rd), .wdata_i(wdata), .rdata_o(rdata),
    .ovf_irq_o(ovf_irq), .inp_irq_o(inp_irq)
  );

  typedef struct packed {
    logic [7:0]  ctrl;
    logic [3:0]  pulses;
    logic        extra;
    logic [15:0] exp_cnt;
    logic        exp_inp;
  } vec_t;

  // event mode / disabled vectors (R2, R3)
  localparam vec_t VEC [6] = '{
    '{8'h50, 4'd3, 1'b1, 16'd4, 1'b1},
    '{8'h40, 4'd3, 1'b1, 16'd3, 1'b1},
    '{8'h00, 4'd3, 1'b1, 16'd0, 1'b0},
    '{8'h30, 4'd3, 1'b1, 16'd0, 1'b0},
    '{8'h50, 4'd0, 1'b0, 16'd0, 1'b0},
    '{8'h40, 4'd6, 1'b0, 16'd6, 1'b1}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a negedge; write lands on the next posedge
  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1;
    @(negedge clk);
    wr = 0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    addr = a; rd = 1;
    #1 d = rdata;
    @(negedge clk);
    rd = 0;
  endtask

  task automatic set_cnt(input logic [15:0] v);
    wr_reg(2, v[15:8]);
    wr_reg(3, v[7:0]);
  endtask

  task automatic get_cnt(output logic [15:0] v);
    logic [7:0] h, l;
    rd_reg(2, h);
    rd_reg(3, l);
    v = {h, l};
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] c;
    idle(3);
    rst_ni = 1;
    idle(2);

    // R1 reset state
    rd_reg(0, b); chk("R1 ctrl", 16'(b), 16'h00);
    rd_reg(1, b); chk("R1 flags", 16'(b), 16'h00);
    get_cnt(c);   chk("R1 count", c, 16'h0000);
    wr_reg(0, 8'h80);
    rd_reg(0, b); chk("R1 bit7", 16'(b), 16'h00);

    // vector walk
    foreach (VEC[i]) begin
      wr_reg(0, 8'h00);
      pin = 0;
      idle(6);
      set_cnt(16'h0000);
      wr_reg(1, 8'h03);
      wr_reg(0, VEC[i].ctrl);
      for (int p = 0; p < int'(VEC[i].pulses); p++) begin
        pin = 1; idle(4);
        pin = 0; idle(4);
      end
      if (VEC[i].extra) begin pin = 1; idle(4); end
      idle(8);
      get_cnt(c);
      chk(VEC[i].ctrl[6] ? "R3 count" : "R2 count", c, VEC[i].exp_cnt);
      rd_reg(1, b);
      chk(VEC[i].ctrl[6] ? "R3 flag" : "R2 flag", 16'(b[0]), 16'(VEC[i].exp_inp));
      wr_reg(0, 8'h00);
      pin = 0;
    end

    // R9 input interrupt
    idle(6);
    wr_reg(1, 8'h03);
    wr_reg(0, 8'h43);
    pin = 1; idle(4); pin = 0; idle(8);
    chk("R9 inp_irq on", 16'(inp_irq), 16'd1);
    chk("R9 ovf_irq off", 16'(ovf_irq), 16'd0);
    wr_reg(0, 8'h40);
    #1 chk("R9 inp_irq masked", 16'(inp_irq), 16'd0);

    // R6 wrap, R7 selective clear
    wr_reg(0, 8'h00);
    wr_reg(1, 8'h03);
    set_cnt(16'hFFFF);
    wr_reg(0, 8'h52);
    pin = 1; idle(8);
    get_cnt(c); chk("R6 wrap count", c, 16'h0000);
    rd_reg(1, b); chk("R6 wrap flag", 16'(b), 16'h03);
    chk("R9 ovf_irq on", 16'(ovf_irq), 16'd1);
    wr_reg(1, 8'h01);
    rd_reg(1, b); chk("R7 clear inp only", 16'(b), 16'h02);
    wr_reg(1, 8'h02);
    rd_reg(1, b); chk("R7 clear ovf", 16'(b), 16'h00);
    wr_reg(0, 8'h00);
    pin = 0; idle(6);

    // R10 byte coherency
    set_cnt(16'h1234);
    get_cnt(c); chk("R10 write pair", c, 16'h1234);
    set_cnt(16'h00FF);
    wr_reg(0, 8'h50);
    rd_reg(2, b); chk("R10 high", 16'(b), 16'h00);
    pin = 1; idle(8);
    rd_reg(3, b); chk("R10 latched low", 16'(b), 16'hFF);
    get_cnt(c); chk("R10 new count", c, 16'h0100);
    wr_reg(0, 8'h00);
    pin = 0; idle(6);

    // R4 gated, high-active
    set_cnt(16'h0000);
    wr_reg(1, 8'h03);
    pin = 1; idle(6);
    wr_reg(0, 8'h60);
    idle(64 * 5 + 8);
    get_cnt(c); chk("R4 gated count", c, 16'd5);
    rd_reg(1, b); chk("R4 no flag in window", 16'(b[0]), 16'd0);
    pin = 0; idle(10);
    rd_reg(1, b); chk("R4 falling flag", 16'(b[0]), 16'd1);
    idle(200);
    get_cnt(c); chk("R4 hold outside window", c, 16'd5);
    wr_reg(0, 8'h00);

    // R5 gated, low-active
    set_cnt(16'h0000);
    wr_reg(1, 8'h03);
    wr_reg(0, 8'h70);
    idle(64 * 3 + 8);
    get_cnt(c); chk("R5 gated count", c, 16'd3);
    pin = 1; idle(10);
    rd_reg(1, b); chk("R5 rising flag", 16'(b[0]), 16'd1);
    idle(200);
    get_cnt(c); chk("R5 hold outside window", c, 16'd3);
    wr_reg(0, 8'h00);

    // R8 wrap coincides with clear write (pin high, gated, first tick 64 cycles after enable)
    wr_reg(1, 8'h03);
    set_cnt(16'hFFFF);
    wr_reg(0, 8'h60);
    idle(63);
    wr_reg(1, 8'h02);
    rd_reg(1, b); chk("R8 set wins", 16'(b[1]), 16'd1);
    get_cnt(c); chk("R8 wrapped", c, 16'h0000);
    wr_reg(0, 8'h00);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule